// File: doc/BRIEF.md
# Trap Return State Unit

This unit carries out the two trap-return operations of a RISC-V style core: the machine-level return and the supervisor-level return. It holds the interrupt-enable and previous-mode status bits, the current privilege level and the virtualization bit. A one-cycle request, together with the two saved exception PCs, produces the status update, the new mode and a redirect PC. If the return is not allowed, the unit raises a trap with a cause code instead. An optional hypervisor extension changes how the previous-virtualization bits are consumed.

All results are registered. The updated state and the one-cycle redirect or trap strobe appear together on the clock edge that follows the request. A simple write port lets surrounding CSR logic load the held state. Only the machine-level return checks privilege. Any other legality checking belongs to a separate block.

Top module: `trap_return_unit`

## Requirements
- R1: A machine return requested while `priv_o` is not machine (3) raises a trap one edge later, with `trap_cause_o` equal to parameter CAUSE_ILL.
- R2: With HAS_C=0, a return whose selected PC (`mepc_i` for machine, `sepc_i` for supervisor) has bits [1:0] nonzero raises a trap with cause CAUSE_MIS. The privilege fault of R1 has priority over this fault.
- R3: A successful machine return makes m_ie take the old m_pie, sets m_pie to 1, sets m_pp to user (0), clears m_pv, and makes the privilege level equal to the old m_pp.
- R4: With HAS_H=1, a successful machine return sets `virt_o` to the old m_pv.
- R5: With HAS_H=1 and `virt_o`=0, a successful supervisor return does the following: s_ie takes the old s_pie, s_pie becomes 1, s_pp and s_pv are cleared, the privilege becomes the old s_pp, and `virt_o` becomes the old s_pv.
- R6: In every other case, a successful supervisor return makes s_ie take s_pie, sets s_pie to 1, sets s_pp to user, and makes the privilege the old s_pp. `virt_o` and s_pv keep their values.
- R7: A successful return pulses `redirect_valid_o` for one cycle on the next edge. `redirect_pc_o` is `mepc_i` for a machine return and `sepc_i` for a supervisor return. `redirect_valid_o` is low in every other cycle.
- R8: When a trap is raised, status, privilege and virtualization keep their values. `trap_valid_o` is high for exactly one cycle and `redirect_valid_o` stays low.
- R9: Synchronous active-high reset sets privilege to machine (3), `virt_o` to 0, the status to all zeros, and both strobes low. Privilege is encoded as user=0, supervisor=1, machine=3.
- R10: `wr_en` loads `wr_status`, `wr_priv` and `wr_virt` on the next edge. The status layout is: bit0 s_ie, bit1 s_pie, bit2 s_pp, bit3 m_ie, bit4 m_pie, bits6:5 m_pp, bit7 m_pv, bit8 s_pv. A return requested in the same cycle is dropped, so neither strobe is raised.
- R11: When both requests are high together, only the machine return is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_mret | input | 1 | Machine return request |
| req_sret | input | 1 | Supervisor return request |
| mepc_i | input | XLEN | Saved machine exception PC |
| sepc_i | input | XLEN | Saved supervisor exception PC |
| wr_en | input | 1 | Load held state from the write port |
| wr_status | input | 9 | Status value to load |
| wr_priv | input | 2 | Privilege value to load |
| wr_virt | input | 1 | Virtualization value to load |
| status_o | output | 9 | Held status bits |
| priv_o | output | 2 | Current privilege level |
| virt_o | output | 1 | Current virtualization bit |
| redirect_valid_o | output | 1 | One-cycle redirect strobe |
| redirect_pc_o | output | XLEN | Redirect target |
| trap_valid_o | output | 1 | One-cycle trap strobe |
| trap_cause_o | output | CAUSE_W | Trap cause code |

## Verification
Random stimulus loads the state with random status bits, privilege levels and virtualization values, then issues machine returns, supervisor returns, both requests together, and idle cycles. Each return uses exception PCs that are either aligned or misaligned.

- Returns issued from every privilege level separate the privilege fault from a legal return.
- Misaligned PCs issued from user mode show that the privilege fault takes priority over the alignment fault.
- Supervisor returns with virtualization on and off separate the two update paths (R5 and R6).
- Writes issued together with a request show that the request is dropped.

// File: rtl/trp_pkg.sv
package trp_pkg;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam int STAT_W = 9;

    typedef struct packed {
        logic       s_pv;
        logic       m_pv;
        logic [1:0] m_pp;
        logic       m_pie;
        logic       m_ie;
        logic       s_pp;
        logic       s_pie;
        logic       s_ie;
    } stat_t;

    typedef struct packed {
        stat_t      st;
        logic [1:0] priv;
        logic       virt;
    } hart_t;

    typedef enum logic [1:0] {
        RET_NONE = 2'd0,
        RET_M    = 2'd1,
        RET_S    = 2'd2
    } ret_e;

    function automatic hart_t do_mret(hart_t cur, logic has_h);
        hart_t n;
        n          = cur;
        n.st.m_ie  = cur.st.m_pie;
        n.st.m_pie = 1'b1;
        n.st.m_pp  = PRIV_U;
        n.st.m_pv  = 1'b0;
        n.priv     = cur.st.m_pp;
        if (has_h) n.virt = cur.st.m_pv;
        return n;
    endfunction

    function automatic hart_t do_sret(hart_t cur, logic has_h);
        hart_t n;
        n          = cur;
        n.st.s_ie  = cur.st.s_pie;
        n.st.s_pie = 1'b1;
        n.st.s_pp  = 1'b0;
        n.priv     = {1'b0, cur.st.s_pp};
        if (has_h && !cur.virt) begin
            n.st.s_pv = 1'b0;
            n.virt    = cur.st.s_pv;
        end
        return n;
    endfunction

endpackage

// File: rtl/trp_fault_check.sv
module trp_fault_check
    import trp_pkg::*;
#(
    parameter int HAS_C     = 0,
    parameter int CAUSE_W   = 5,
    parameter int CAUSE_ILL = 2,
    parameter int CAUSE_MIS = 0
) (
    input  ret_e               op,
    input  logic [1:0]         priv,
    input  logic [1:0]         epc_lo,
    output logic               fault,
    output logic [CAUSE_W-1:0] cause
);
    logic misaligned;
    logic bad_priv;

    generate
        if (HAS_C == 0) begin : g_align
            assign misaligned = |epc_lo;
        end else begin : g_noalign
            logic unused_lo;
            assign unused_lo  = |epc_lo;
            assign misaligned = 1'b0;
        end
    endgenerate

    assign bad_priv = (op == RET_M) && (priv != PRIV_M);

    always_comb begin
        fault = 1'b0;
        cause = '0;
        if (op != RET_NONE) begin
            if (bad_priv) begin
                fault = 1'b1;
                cause = CAUSE_W'(CAUSE_ILL);
            end else if (misaligned) begin
                fault = 1'b1;
                cause = CAUSE_W'(CAUSE_MIS);
            end
        end
    end
endmodule

// File: rtl/trp_next_state.sv
module trp_next_state
    import trp_pkg::*;
#(
    parameter int HAS_H = 1
) (
    input  ret_e  op,
    input  hart_t cur,
    output hart_t nxt
);
    localparam logic H_EN = (HAS_H != 0);

    always_comb begin
        unique case (op)
            RET_M:   nxt = do_mret(cur, H_EN);
            RET_S:   nxt = do_sret(cur, H_EN);
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
    import trp_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int HAS_C     = 0,
    parameter int HAS_H     = 1,
    parameter int CAUSE_W   = 5,
    parameter int CAUSE_ILL = 2,
    parameter int CAUSE_MIS = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_mret,
    input  logic               req_sret,
    input  logic [XLEN-1:0]    mepc_i,
    input  logic [XLEN-1:0]    sepc_i,
    input  logic               wr_en,
    input  logic [8:0]         wr_status,
    input  logic [1:0]         wr_priv,
    input  logic               wr_virt,
    output logic [8:0]         status_o,
    output logic [1:0]         priv_o,
    output logic               virt_o,
    output logic               redirect_valid_o,
    output logic [XLEN-1:0]    redirect_pc_o,
    output logic               trap_valid_o,
    output logic [CAUSE_W-1:0] trap_cause_o
);
    localparam logic H_EN = (HAS_H != 0);

    hart_t              hart_q;
    hart_t              hart_nxt;
    ret_e               op;
    logic [XLEN-1:0]    epc_sel;
    logic               fault;
    logic [CAUSE_W-1:0] cause;

    always_comb begin
        if (wr_en)         op = RET_NONE;
        else if (req_mret) op = RET_M;
        else if (req_sret) op = RET_S;
        else               op = RET_NONE;
    end

    assign epc_sel = (op == RET_S) ? sepc_i : mepc_i;

    trp_fault_check #(
        .HAS_C    (HAS_C),
        .CAUSE_W  (CAUSE_W),
        .CAUSE_ILL(CAUSE_ILL),
        .CAUSE_MIS(CAUSE_MIS)
    ) u_fault (
        .op    (op),
        .priv  (hart_q.priv),
        .epc_lo(epc_sel[1:0]),
        .fault (fault),
        .cause (cause)
    );

    trp_next_state #(
        .HAS_H(HAS_H)
    ) u_next (
        .op (op),
        .cur(hart_q),
        .nxt(hart_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hart_q.st        <= '0;
            hart_q.priv      <= PRIV_M;
            hart_q.virt      <= 1'b0;
            redirect_valid_o <= 1'b0;
            redirect_pc_o    <= '0;
            trap_valid_o     <= 1'b0;
            trap_cause_o     <= '0;
        end else begin
            redirect_valid_o <= 1'b0;
            trap_valid_o     <= 1'b0;
            if (wr_en) begin
                hart_q.st   <= stat_t'(wr_status);
                hart_q.priv <= wr_priv;
                hart_q.virt <= wr_virt & H_EN;
            end else if (op != RET_NONE) begin
                if (fault) begin
                    trap_valid_o <= 1'b1;
                    trap_cause_o <= cause;
                end else begin
                    hart_q           <= hart_nxt;
                    redirect_valid_o <= 1'b1;
                    redirect_pc_o    <= epc_sel;
                end
            end
        end
    end

    assign status_o = hart_q.st;
    assign priv_o   = hart_q.priv;
    assign virt_o   = hart_q.virt;
endmodule

// File: rtl/trp_checker.sv
module trp_checker #(
    parameter int XLEN      = 32,
    parameter int HAS_C     = 0,
    parameter int CAUSE_W   = 5,
    parameter int CAUSE_ILL = 2,
    parameter int CAUSE_MIS = 0
) (
    input logic               clk,
    input logic               rst,
    input logic               req_mret,
    input logic               req_sret,
    input logic [XLEN-1:0]    mepc_i,
    input logic [XLEN-1:0]    sepc_i,
    input logic               wr_en,
    input logic [8:0]         status_o,
    input logic [1:0]         priv_o,
    input logic               virt_o,
    input logic               redirect_valid_o,
    input logic [XLEN-1:0]    redirect_pc_o,
    input logic               trap_valid_o,
    input logic [CAUSE_W-1:0] trap_cause_o
);
    p_trap_excl_r8: assert property (@(posedge clk) disable iff (rst)
        trap_valid_o |-> !redirect_valid_o);

    p_trap_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        trap_valid_o |-> ($stable(status_o) && $stable(priv_o) && $stable(virt_o)));

    p_mret_priv_r1: assert property (@(posedge clk) disable iff (rst)
        (req_mret && !wr_en && priv_o != 2'd3)
        |=> (trap_valid_o && trap_cause_o == CAUSE_W'(CAUSE_ILL)));

    generate
        if (HAS_C == 0) begin : g_mis
            p_mret_misalign_r2: assert property (@(posedge clk) disable iff (rst)
                (req_mret && !wr_en && priv_o == 2'd3 && mepc_i[1:0] != 2'b00)
                |=> (trap_valid_o && trap_cause_o == CAUSE_W'(CAUSE_MIS)));
        end
    endgenerate

    p_mret_fields_r3: assert property (@(posedge clk) disable iff (rst)
        (req_mret && !wr_en && priv_o == 2'd3 && mepc_i[1:0] == 2'b00)
        |=> (status_o[6:5] == 2'd0 && status_o[4] && !status_o[7]
             && priv_o == $past(status_o[6:5])));

    p_sret_redirect_r7: assert property (@(posedge clk) disable iff (rst)
        (req_sret && !req_mret && !wr_en && sepc_i[1:0] == 2'b00)
        |=> (redirect_valid_o && redirect_pc_o == $past(sepc_i)));

    p_write_drop_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (!trap_valid_o && !redirect_valid_o));
endmodule

bind trap_return_unit trp_checker #(
    .XLEN     (XLEN),
    .HAS_C    (HAS_C),
    .CAUSE_W  (CAUSE_W),
    .CAUSE_ILL(CAUSE_ILL),
    .CAUSE_MIS(CAUSE_MIS)
) u_chk (.*);

// File: tb/tb_trap_return_unit.sv
module tb_trap_return_unit;
    localparam int XLEN = 32;
    localparam int CW   = 5;
    localparam int CILL = 2;
    localparam int CMIS = 0;

    logic            clk = 1'b0;
    logic            rst;
    logic            req_mret, req_sret, wr_en, wr_virt;
    logic [XLEN-1:0] mepc_i, sepc_i;
    logic [8:0]      wr_status;
    logic [1:0]      wr_priv;
    logic [8:0]      status_o;
    logic [1:0]      priv_o;
    logic            virt_o, redirect_valid_o, trap_valid_o;
    logic [XLEN-1:0] redirect_pc_o;
    logic [CW-1:0]   trap_cause_o;

    trap_return_unit #(.XLEN(XLEN), .HAS_C(0), .HAS_H(1), .CAUSE_W(CW),
                       .CAUSE_ILL(CILL), .CAUSE_MIS(CMIS)) dut (.*);

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [8:0] m_st;
    logic [1:0] m_priv;
    logic       m_virt;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] pick_priv(input int unsigned r);
        case (r % 3)
            0: return 2'd0;
            1: return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [8:0] legal_status(input logic [8:0] s);
        logic [8:0] t;
        t = s;
        if (t[6:5] == 2'd2) t[6:5] = 2'd3;
        return t;
    endfunction

    task automatic step(input bit m, input bit s, input bit w, input logic [8:0] ws,
                        input logic [1:0] wp, input bit wv,
                        input logic [XLEN-1:0] me, input logic [XLEN-1:0] se);
        bit exp_rv, exp_tv;
        logic [XLEN-1:0] exp_pc, epc;
        logic [CW-1:0] exp_c;
        string tag, vtag;
        exp_rv = 0; exp_tv = 0; exp_pc = '0; exp_c = '0;
        req_mret = m; req_sret = s; wr_en = w;
        wr_status = ws; wr_priv = wp; wr_virt = wv;
        mepc_i = me; sepc_i = se;
        tag = "R7"; vtag = "R7";
        if (w) begin
            tag = "R10"; vtag = "R10";
            m_st = ws; m_priv = wp; m_virt = wv;
        end else if (m || s) begin
            epc = m ? me : se;
            if (m && m_priv != 2'd3) begin
                exp_tv = 1; exp_c = CW'(CILL); tag = "R1";
            end else if (epc[1:0] != 2'b00) begin
                exp_tv = 1; exp_c = CW'(CMIS); tag = "R2";
            end
            if (exp_tv) begin
                vtag = "R8";
            end else begin
                exp_rv = 1; exp_pc = epc;
                if (m) begin
                    tag = (s) ? "R11" : "R3"; vtag = "R4";
                    m_st[3] = m_st[4]; m_st[4] = 1'b1;
                    m_priv = m_st[6:5]; m_st[6:5] = 2'd0;
                    m_virt = m_st[7]; m_st[7] = 1'b0;
                end else begin
                    m_st[0] = m_st[1]; m_st[1] = 1'b1;
                    m_priv = {1'b0, m_st[2]}; m_st[2] = 1'b0;
                    if (!m_virt) begin
                        tag = "R5"; m_virt = m_st[8]; m_st[8] = 1'b0;
                    end else begin
                        tag = "R6";
                    end
                    vtag = tag;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk({tag, " status"}, 64'(status_o), 64'(m_st));
        chk({tag, " priv"}, 64'(priv_o), 64'(m_priv));
        chk({vtag, " virt"}, 64'(virt_o), 64'(m_virt));
        chk("R7 redirect strobe", 64'(redirect_valid_o), 64'(exp_rv));
        if (exp_rv) chk("R7 redirect pc", 64'(redirect_pc_o), 64'(exp_pc));
        chk("R8 trap strobe", 64'(trap_valid_o), 64'(exp_tv));
        if (exp_tv) chk({tag, " cause"}, 64'(trap_cause_o), 64'(exp_c));
        req_mret = 0; req_sret = 0; wr_en = 0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        rst = 1; req_mret = 0; req_sret = 0; wr_en = 0;
        wr_status = '0; wr_priv = '0; wr_virt = 0; mepc_i = '0; sepc_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R9 reset state
        chk("R9 status", 64'(status_o), 64'h0);
        chk("R9 priv", 64'(priv_o), 64'd3);
        chk("R9 virt", 64'(virt_o), 64'd0);
        chk("R9 strobes", 64'({redirect_valid_o, trap_valid_o}), 64'd0);
        m_st = '0; m_priv = 2'd3; m_virt = 0;

        // R1 over R2: user-mode machine return with misaligned PC
        step(0, 0, 1, 9'h0F0, 2'd0, 0, '0, '0);
        step(1, 0, 0, '0, '0, 0, 32'h0000_1002, '0);
        // R2 misaligned machine return from machine mode
        step(0, 0, 1, 9'h070, 2'd3, 0, '0, '0);
        step(1, 0, 0, '0, '0, 0, 32'h0000_2001, '0);
        // R3/R4 machine return restoring virt
        step(0, 0, 1, 9'h0B0, 2'd3, 0, '0, '0);
        step(1, 0, 0, '0, '0, 0, 32'h0000_3000, '0);
        // R5 supervisor return with virt off restores s_pv
        step(0, 0, 1, 9'h106, 2'd1, 0, '0, '0);
        step(0, 1, 0, '0, '0, 0, '0, 32'h0000_4000);
        // R6 supervisor return with virt on
        step(0, 0, 1, 9'h106, 2'd1, 1, '0, '0);
        step(0, 1, 0, '0, '0, 0, '0, 32'h0000_5004);
        // R11 both requests
        step(0, 0, 1, 9'h070, 2'd3, 0, '0, '0);
        step(1, 1, 0, '0, '0, 0, 32'h0000_6000, 32'h0000_7000);
        // R10 write with request dropped
        step(1, 1, 1, 9'h0C3, 2'd1, 1, 32'h0000_8000, 32'h0000_9000);

        for (int i = 0; i < 600; i++) begin
            int unsigned r;
            logic [XLEN-1:0] me, se;
            r = $urandom % 10;
            me = $urandom & ~32'h3;
            se = $urandom & ~32'h3;
            if ($urandom % 4 == 0) me[1:0] = 2'(1 + $urandom % 3);
            if ($urandom % 4 == 0) se[1:0] = 2'(1 + $urandom % 3);
            if (r < 2)      step($urandom % 2 == 0, 0, 1, legal_status(9'($urandom)),
                                 pick_priv($urandom), 1'($urandom), me, se);
            else if (r < 5) step(1, 0, 0, '0, '0, 0, me, se);
            else if (r < 8) step(0, 1, 0, '0, '0, 0, me, se);
            else if (r < 9) step(1, 1, 0, '0, '0, 0, me, se);
            else            step(0, 0, 0, '0, '0, 0, me, se);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule